// File: doc/BRIEF.md
# I2C slave address recognizer

This block sits behind an I2C bit engine that already turns the bus into START and STOP strobes and whole received bytes. After every START it examines the first one or two bytes to decide whether the device is being addressed. It supports a 7-bit own address, a 10-bit own address, and an optional answer to the general call address. For each address byte it produces an acknowledge request (ACK or NACK). When the address is fully matched it raises a one-cycle interrupt, sets a slave-mode flag, and latches the transfer direction.

Two 8-bit configuration registers are written and read through a small register port. The primary register holds the 7-bit address in bits [7:1] and the general call enable in bit 0. Its bits [2:1] also serve as the upper two bits of a 10-bit address. The extended register holds the lower eight bits of a 10-bit address. The full 10-bit address is always visible on a dedicated output.

Top module: `i2c_addr_match`

## Requirements
- R1: Both registers reset to 00h. When reg_we_i is high, reg_wdata_i is written to the register chosen by reg_sel_i (0 = primary, 1 = extended). reg_rdata_o shows the register chosen by reg_sel_i in the same cycle.
- R2: The first byte after a START is a 7-bit match when its bits [7:1] equal primary bits [7:1], its bits [7:3] are not 11110, and its bits [7:1] are not zero. On such a byte, the cycle after the byte strobe shows ack_vld_o=1, ack_o=1 and irq_o=1. From then on slave_o=1, and dir_o holds bit 0 of the byte.
- R3: A first byte of exactly 00h is the general call. If primary bit 0 is 1, it is acknowledged with an interrupt and slave mode, and dir_o=0. If primary bit 0 is 0, it gets a NACK (ack_vld_o=1, ack_o=0) and no interrupt.
- R4: A first byte whose bits [7:3] are 11110 selects 10-bit addressing, even when it also equals the 7-bit address. If its bits [2:1] equal primary bits [2:1], it gets an ACK with no interrupt, and slave_o stays 0.
- R5: In 10-bit mode, if the second byte equals the extended register, it gets an ACK with an interrupt. slave_o then becomes 1, and dir_o takes bit 0 of the first byte.
- R6: A mismatch on either address byte gives a NACK with no interrupt. After the address phase ends, whether matched or not, further bytes produce no acknowledge request and no interrupt until the next START.
- R7: A STOP or a START (including a repeated START) clears slave_o in the following cycle. A START restarts address recognition. STOP takes priority if both strobes arrive together. irq_o and ack_vld_o are single-cycle pulses.
- R8: match_addr_o equals {primary[2:1], extended[7:0]} at all times.
- R9: A register write in the same cycle as an address byte strobe does not affect that byte's comparison. The write takes effect from the next cycle.
- R10: Bytes received with no START since reset or since the last STOP are ignored, with no acknowledge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START strobe |
| stop_i | input | 1 | STOP strobe |
| byte_vld_i | input | 1 | Received-byte strobe |
| byte_i | input | 8 | Received byte |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | Register select: 0 primary, 1 extended |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register read data |
| ack_vld_o | output | 1 | Acknowledge request valid (one cycle) |
| ack_o | output | 1 | 1 = ACK, 0 = NACK, meaningful with ack_vld_o |
| irq_o | output | 1 | Address-matched interrupt pulse |
| slave_o | output | 1 | Addressed as slave |
| dir_o | output | 1 | Latched direction bit (1 = read) |
| match_addr_o | output | 10 | 10-bit own address |

## Verification
A register write and an address comparison can fall in the same clock cycle. The bench provokes this by rewriting the primary register in the same cycle as the strobe of a first byte that matches only the old address. It expects a full ACK with an interrupt for that byte, the new value on readback afterwards, and a NACK for the same byte after a fresh START. The priority of 10-bit selection over an equal 7-bit address is judged the same way, through the acknowledge and interrupt pattern the scoreboard expects for each byte.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_vld_i,
  input  logic [AW-1:0] byte_i,
  input  logic          reg_we_i,
  input  logic          reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  output logic          ack_vld_o,
  output logic          ack_o,
  output logic          irq_o,
  output logic          slave_o,
  output logic          dir_o,
  output logic [AW+1:0] match_addr_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR1, ST_ADDR2, ST_DONE} st_t;

  st_t           st;
  logic [AW-1:0] pri_q, ext_q;
  logic          dir_pend;

  wire ten_hdr  = (byte_i[7:3] == 5'b11110);
  wire gc_field = (byte_i[7:1] == 7'd0);

  assign reg_rdata_o  = reg_sel_i ? ext_q : pri_q;
  assign match_addr_o = {pri_q[2:1], ext_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pri_q     <= '0;
      ext_q     <= '0;
      dir_pend  <= 1'b0;
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
      irq_o     <= 1'b0;
      slave_o   <= 1'b0;
      dir_o     <= 1'b0;
    end else begin
      if (reg_we_i) begin
        if (reg_sel_i) ext_q <= reg_wdata_i;
        else           pri_q <= reg_wdata_i;
      end
      ack_vld_o <= 1'b0;
      irq_o     <= 1'b0;
      if (stop_i) begin
        st      <= ST_IDLE;
        slave_o <= 1'b0;
      end else if (start_i) begin
        st      <= ST_ADDR1;
        slave_o <= 1'b0;
      end else if (byte_vld_i) begin
        case (st)
          ST_ADDR1: begin
            ack_vld_o <= 1'b1;
            ack_o     <= 1'b0;
            st        <= ST_DONE;
            if (ten_hdr) begin
              if (byte_i[2:1] == pri_q[2:1]) begin
                ack_o    <= 1'b1;
                st       <= ST_ADDR2;
                dir_pend <= byte_i[0];
              end
            end else if (gc_field) begin
              if (pri_q[0] && !byte_i[0]) begin
                ack_o   <= 1'b1;
                irq_o   <= 1'b1;
                slave_o <= 1'b1;
                dir_o   <= 1'b0;
              end
            end else if (byte_i[7:1] == pri_q[7:1]) begin
              ack_o   <= 1'b1;
              irq_o   <= 1'b1;
              slave_o <= 1'b1;
              dir_o   <= byte_i[0];
            end
          end
          ST_ADDR2: begin
            ack_vld_o <= 1'b1;
            st        <= ST_DONE;
            ack_o     <= (byte_i == ext_q);
            if (byte_i == ext_q) begin
              irq_o   <= 1'b1;
              slave_o <= 1'b1;
              dir_o   <= dir_pend;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_irq_acked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ack_vld_o && ack_o));
  a_r4_silent_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR2) |-> (!irq_o && !slave_o));
  a_r5_slave_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_o) |-> irq_o);
  a_r6_ack_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> $past(byte_vld_i));
  a_r7_clear_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i || start_i) |=> !slave_o);
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, byte_vld_i = 0, reg_we_i = 0, reg_sel_i = 0;
  logic [7:0] byte_i = 0, reg_wdata_i = 0, reg_rdata_o;
  logic ack_vld_o, ack_o, irq_o, slave_o, dir_o;
  logic [9:0] match_addr_o;

  int n_tests = 0, n_fail = 0;
  logic [3:0] expq[$];
  logic seen = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_addr_match dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // item: {req_tag(1:reserved), ackv, ack, irq}
  always @(posedge clk) seen <= byte_vld_i;
  always @(negedge clk) begin
    if (seen && rst_n) begin
      if (expq.size() == 0) chk("scoreboard empty", 1, 0);
      else begin
        logic [3:0] e;
        e = expq.pop_front();
        chk("R6 ack_vld", ack_vld_o, e[2]);
        if (e[2]) chk("R2 ack", ack_o, e[1]);
        chk("R5 irq", irq_o, e[0]);
      end
    end
  end

  task automatic strobe_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask
  task automatic strobe_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask
  task automatic send(input logic [7:0] b, input logic [2:0] e);
    @(negedge clk) begin byte_vld_i = 1; byte_i = b; expq.push_back({1'b0, e}); end
    @(negedge clk) byte_vld_i = 0;
  endtask
  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk) begin reg_we_i = 1; reg_sel_i = sel; reg_wdata_i = d; end
    @(negedge clk) reg_we_i = 0;
  endtask
  task automatic rd(input string tag, input logic sel, input logic [7:0] exp);
    @(negedge clk) reg_sel_i = sel;
    #1 chk(tag, reg_rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R1 reset primary", 0, 8'h00);
    rd("R1 reset extended", 1, 8'h00);
    chk("R7 reset slave", slave_o, 0);
    chk("R7 reset irq", irq_o, 0);
    chk("R8 reset addr", match_addr_o, 0);

    wr(0, 8'hA5);
    rd("R1 primary write", 0, 8'hA5);
    send(8'hA4, 3'b000);                       // R10 no START yet
    strobe_start();
    send(8'hA5, 3'b111);                       // R2 7-bit read
    chk("R2 slave", slave_o, 1);
    chk("R2 dir", dir_o, 1);
    send(8'h33, 3'b000);                       // R6 after address phase
    strobe_stop();
    chk("R7 stop clears slave", slave_o, 0);
    send(8'hA5, 3'b000);                       // R10 after STOP

    strobe_start();
    send(8'h00, 3'b111);                       // R3 gc enabled
    chk("R3 gc slave", slave_o, 1);
    chk("R3 gc dir", dir_o, 0);
    strobe_start();
    chk("R7 repeated start clears slave", slave_o, 0);
    wr(0, 8'hA4);
    strobe_start();
    send(8'h00, 3'b110 & 3'b100);              // R3 gc disabled -> NACK
    chk("R3 gc off slave", slave_o, 0);

    strobe_start();
    send(8'hB0, 3'b100);                       // R6 7-bit mismatch
    send(8'hA4, 3'b000);                       // R6 ignored until START

    wr(1, 8'h3C);
    rd("R1 extended write", 1, 8'h3C);
    chk("R8 match addr", match_addr_o, 10'h23C);
    strobe_start();
    send(8'hF4, 3'b110);                       // R4 first byte silent ACK
    chk("R4 slave stays low", slave_o, 0);
    send(8'h3C, 3'b111);                       // R5
    chk("R5 slave", slave_o, 1);
    chk("R5 dir write", dir_o, 0);

    strobe_start();
    send(8'hF2, 3'b100);                       // R6 wrong upper bits
    strobe_start();
    send(8'hF5, 3'b110);
    send(8'h3D, 3'b100);                       // R6 wrong lower byte
    chk("R6 slave after mismatch", slave_o, 0);
    strobe_start();
    send(8'hF5, 3'b110);
    send(8'h3C, 3'b111);                       // R5 read
    chk("R5 dir read", dir_o, 1);

    wr(0, 8'hF4);
    strobe_start();
    send(8'hF4, 3'b110);                       // R4 10-bit priority
    chk("R4 priority slave", slave_o, 0);
    send(8'h3C, 3'b111);

    wr(0, 8'hA4);
    strobe_start();
    @(negedge clk) begin
      byte_vld_i = 1; byte_i = 8'hA4; expq.push_back(4'b0111);  // R9 old value used
      reg_we_i = 1; reg_sel_i = 0; reg_wdata_i = 8'hB0;
    end
    @(negedge clk) begin byte_vld_i = 0; reg_we_i = 0; end
    rd("R9 new value visible", 0, 8'hB0);
    strobe_start();
    send(8'hA4, 3'b100);                       // R9 new value compared

    repeat (3) @(negedge clk);
    chk("scoreboard drained", expq.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule